// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers interrupt requests for a CPU and decides which one the CPU takes next. It serves a set of maskable sources, one non-maskable source and two traps raised by the CPU itself: a software interrupt and an illegal-instruction trap. Software gives each maskable source a 3-bit priority level. The controller latches each rising request edge as a pending flag and picks the most urgent eligible request. It presents that request's fixed vector number and level on registered outputs, which hold until the CPU acknowledges them.

Eligibility comes from a 3-bit numeric threshold held for the CPU, and there is no per-source enable. A maskable request passes only when its level is at least the threshold. The non-maskable source always sits at level 7, so every threshold admits it. The two traps skip the threshold entirely. The threshold changes through two commands. An enable command writes its operand into the threshold. A disable command forces the threshold to 7.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Each maskable source holds a 3-bit level, written through `cfg_we`/`cfg_idx`/`cfg_lvl`. A write of 7 is stored as 6. A source whose level is 0 latches no request edge and never requests.
- R2: The non-maskable request is reported at level 7 with vector 0x04, and it is accepted under every threshold value, including 7.
- R3: When several eligible maskable requests are pending, the one with the highest level is presented first.
- R4: A maskable request whose level is below the threshold is not presented. It stays pending and is presented once the threshold falls to its level or lower.
- R5: An enable command loads its operand into the threshold, and an operand of 0 loads 1. `mask_level` shows the new value right after the clock edge that takes the command.
- R6: A disable command sets the threshold to 7. When disable and enable arrive in the same cycle, disable wins.
- R7: A threshold change applies to the very next arbitration. A request that was held back by the old threshold appears on `irq_valid` one clock edge after the edge that took the enable command.
- R8: Traps bypass the threshold. Fixed precedence is illegal-instruction trap, then software interrupt, then non-maskable, then maskable, and each trap is reported at level 7.
- R9: Vectors are fixed: illegal trap 0x02, software interrupt 0x03, non-maskable 0x04, maskable source i at 0x10+i.
- R10: Among eligible maskable requests of equal level, the lower source index is presented first.
- R11: A rising request edge sets a pending flag. Only an acknowledge of that source's presented vector clears it. An edge that arrives in the acknowledge cycle leaves the flag set, so the source is presented again.
- R12: `irq_valid`, `irq_vector` and `irq_level` are registered and hold unchanged until `irq_ack`. A more urgent later request does not displace them. After an acknowledge, `irq_valid` is low for at least one cycle.
- R13: After reset, no flag is pending, every level is 0, the threshold is 7 and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | N_SRC | Maskable request lines, rising edge sets pending |
| nmi_req | input | 1 | Non-maskable request, rising edge sets pending |
| swi_req | input | 1 | Software-interrupt trap from the CPU |
| ill_req | input | 1 | Illegal-instruction trap from the CPU |
| cfg_we | input | 1 | Level table write strobe |
| cfg_idx | input | IDX_W | Source index for the level write |
| cfg_lvl | input | 3 | Level to write |
| mask_en | input | 1 | Enable command, load threshold from operand |
| mask_en_lvl | input | 3 | Enable command operand |
| mask_dis | input | 1 | Disable command, threshold to 7 |
| irq_ack | input | 1 | CPU acknowledges the presented request |
| irq_valid | output | 1 | A request is presented |
| irq_vector | output | VEC_W | Vector of the presented request |
| irq_level | output | 3 | Level of the presented request |
| mask_level | output | 3 | Current threshold value |

## Verification
A wrong level-table entry or threshold value shows up at the first arbitration that follows. Either a request appears one edge after it becomes eligible when it should have been blocked, or it fails to appear when it should have. The bench therefore samples `irq_valid` on the exact cycle that R7 fixes. A corrupted pending flag shows up as a vector that is lost or repeated across the sequence of acknowledges. The bench drains every scenario to the end, checking both the order of vectors and how many there are. A broken hold register shows up as a vector that changes without an acknowledge within one cycle of a more urgent edge.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_TOP  = 3'd7;
  localparam lvl_t LVL_MAXM = 3'd6;
  localparam lvl_t LVL_MIN  = 3'd1;

  function automatic lvl_t clamp_maskable(input lvl_t l);
    return (l == LVL_TOP) ? LVL_MAXM : l;
  endfunction

  function automatic lvl_t enable_operand(input lvl_t l);
    return (l == 3'd0) ? LVL_MIN : l;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] arm_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic set_w;
    assign set_w     = req_i[g] & ~req_q[g] & arm_i[g];
    assign pend_d[g] = set_w | (pend_q[g] & ~clr_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        req_q[g]  <= req_i[g];
        pend_q[g] <= pend_d[g];
      end
    end

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] && !clr_i[g] |=> pend_q[g]); // R11
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import lvl_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_cmd,
  input  lvl_t en_lvl,
  input  logic dis_cmd,
  output lvl_t mask_o
);
  lvl_t mask_q;
  lvl_t mask_d;
  logic mask_ce;

  always_comb begin
    mask_ce = en_cmd | dis_cmd;
    mask_d  = dis_cmd ? LVL_TOP : enable_operand(en_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= LVL_TOP;
    else if (mask_ce) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != 3'd0); // R5
  AST_DIS_TO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> mask_q == 3'd7); // R6
  AST_EN_ZERO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    en_cmd && !dis_cmd && en_lvl == 3'd0 |=> mask_q == 3'd1); // R5
endmodule

// File: rtl/irq_lvl_arb.sv
module irq_lvl_arb
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  lvl_t             cfg_lvl,
  input  lvl_t             mask_i,
  input  logic [N-1:0]     pend_i,
  output logic [N-1:0]     on_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  lvl_t lvl_q [N];

  for (genvar g = 0; g < N; g++) begin : g_tab
    logic we_w;
    assign we_w    = cfg_we && (cfg_idx == IDX_W'(g));
    assign on_o[g] = (lvl_q[g] != 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lvl_q[g] <= 3'd0;
      else if (we_w) lvl_q[g] <= clamp_maskable(cfg_lvl);
    end
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = 3'd0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (pend_i[i] && on_o[i] && (lvl_q[i] >= mask_i) &&
          (!hit_o || lvl_q[i] >= lvl_o)) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_q[i];
      end
    end
  end

  AST_HIT_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (lvl_o >= mask_i) && (lvl_o != 3'd0) && (lvl_o != 3'd7)); // R4
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned VEC_W    = 8,
  parameter logic [7:0]  VEC_BASE = 8'h10,
  parameter logic [7:0]  VEC_ILL  = 8'h02,
  parameter logic [7:0]  VEC_SWI  = 8'h03,
  parameter logic [7:0]  VEC_NMI  = 8'h04,
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_req,
  input  logic             nmi_req,
  input  logic             swi_req,
  input  logic             ill_req,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [2:0]       cfg_lvl,
  input  logic             mask_en,
  input  logic [2:0]       mask_en_lvl,
  input  logic             mask_dis,
  input  logic             irq_ack,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  output logic [2:0]       irq_level,
  output logic [2:0]       mask_level
);
  localparam int unsigned N_TOT   = N_SRC + 3;
  localparam int unsigned POS_NMI = N_SRC;
  localparam int unsigned POS_SWI = N_SRC + 1;
  localparam int unsigned POS_ILL = N_SRC + 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [N_TOT-1:0] pend_w, clr_w, arm_w, req_w;
  logic [N_SRC-1:0] on_w;
  logic             hit_w;
  logic [IDX_W-1:0] idx_w;
  lvl_t             alvl_w, mask_w;

  assign req_w = {ill_req, swi_req, nmi_req, src_req};
  assign arm_w = {3'b111, on_w};

  irq_pend_bank #(.N(N_TOT)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_w), .arm_i(arm_w),
    .clr_i(clr_w), .pend_o(pend_w)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .en_cmd(mask_en), .en_lvl(mask_en_lvl),
    .dis_cmd(mask_dis), .mask_o(mask_w)
  );

  irq_lvl_arb #(.N(N_SRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lvl(cfg_lvl), .mask_i(mask_w), .pend_i(pend_w[N_SRC-1:0]),
    .on_o(on_w), .hit_o(hit_w), .idx_o(idx_w), .lvl_o(alvl_w)
  );

  // fixed precedence: illegal trap, software trap, non-maskable, maskable
  logic             any_w;
  logic [N_TOT-1:0] sel_oh_w;
  logic [VEC_W-1:0] sel_vec_w;
  lvl_t             sel_lvl_w;

  always_comb begin
    any_w     = 1'b1;
    sel_oh_w  = '0;
    sel_vec_w = '0;
    sel_lvl_w = LVL_TOP;
    if (pend_w[POS_ILL]) begin
      sel_oh_w[POS_ILL] = 1'b1;
      sel_vec_w         = VEC_W'(VEC_ILL);
    end else if (pend_w[POS_SWI]) begin
      sel_oh_w[POS_SWI] = 1'b1;
      sel_vec_w         = VEC_W'(VEC_SWI);
    end else if (pend_w[POS_NMI]) begin
      sel_oh_w[POS_NMI] = 1'b1;
      sel_vec_w         = VEC_W'(VEC_NMI);
    end else if (hit_w) begin
      sel_oh_w[idx_w]   = 1'b1;
      sel_vec_w         = VEC_W'(VEC_BASE) + VEC_W'(idx_w);
      sel_lvl_w         = alvl_w;
    end else begin
      any_w     = 1'b0;
      sel_lvl_w = 3'd0;
    end
  end

  // presented request register
  logic             valid_q, valid_d, out_ce;
  logic [N_TOT-1:0] held_q, held_d;
  logic [VEC_W-1:0] vec_q;
  lvl_t             lvl_q;

  always_comb begin
    out_ce  = valid_q ? irq_ack : any_w;
    valid_d = !valid_q;
    held_d  = valid_q ? '0 : sel_oh_w;
    clr_w   = (valid_q && irq_ack) ? held_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      held_q  <= '0;
      vec_q   <= '0;
      lvl_q   <= 3'd0;
    end else if (out_ce) begin
      valid_q <= valid_d;
      held_q  <= held_d;
      vec_q   <= sel_vec_w;
      lvl_q   <= sel_lvl_w;
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;
  assign irq_level  = lvl_q;
  assign mask_level = mask_w;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vector) && $stable(irq_level)); // R12
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid); // R12
  AST_NMI_TOP_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_vector == VEC_W'(VEC_NMI) |-> irq_level == 3'd7); // R2
  AST_ONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $countones(held_q) == 1); // R11
endmodule

// File: tb/lvl_irq_ctrl_bench.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] src_req;
  logic       nmi_req, swi_req, ill_req;
  logic       cfg_we;
  logic [2:0] cfg_idx, cfg_lvl;
  logic       mask_en, mask_dis;
  logic [2:0] mask_en_lvl;
  logic       irq_ack;
  logic       irq_valid;
  logic [7:0] irq_vector;
  logic [2:0] irq_level, mask_level;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl u_lvl_irq_ctrl (
    .clk(clk), .rst_ni(rst_ni), .src_req(src_req), .nmi_req(nmi_req),
    .swi_req(swi_req), .ill_req(ill_req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lvl(cfg_lvl), .mask_en(mask_en), .mask_en_lvl(mask_en_lvl),
    .mask_dis(mask_dis), .irq_ack(irq_ack), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_level(irq_level), .mask_level(mask_level)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int idx, input int lvl);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_lvl = 3'(lvl);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic enable(input int lvl);
    mask_en = 1'b1; mask_en_lvl = 3'(lvl);
    tick();
    mask_en = 1'b0;
  endtask

  task automatic disable_all();
    mask_dis = 1'b1;
    tick();
    mask_dis = 1'b0;
  endtask

  task automatic pulse(input int idx);
    src_req[idx] = 1'b1;
    tick();
    src_req[idx] = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic expect_req(input string req, input int vec, input int lvl);
    check({req, " valid"}, int'(irq_valid), 1);
    check({req, " vector"}, int'(irq_vector), vec);
    check({req, " level"}, int'(irq_level), lvl);
    ack();
    check({req, " drop after ack"}, int'(irq_valid), 0);
    tick();
  endtask

  task automatic t_reset();
    check("R13 valid", int'(irq_valid), 0);
    check("R13 mask", int'(mask_level), 7);
  endtask

  task automatic t_level_zero();
    enable(1);
    pulse(0);             // level 0 at reset: edge ignored (R1)
    cfg(0, 3);
    tick(); tick();
    check("R1 level0 no request", int'(irq_valid), 0);
    cfg(1, 7);            // clamps to 6 (R1)
    pulse(1);
    tick();
    expect_req("R1 clamp", 8'h11, 6);
  endtask

  task automatic t_mask_block();
    disable_all();
    cfg(2, 4);
    pulse(2);
    tick(); tick();
    check("R4 blocked", int'(irq_valid), 0);
    enable(4);
    check("R5 mask loaded", int'(mask_level), 4);
    check("R7 not yet", int'(irq_valid), 0);
    tick();
    expect_req("R7 next arbitration", 8'h12, 4);
    enable(0);
    check("R5 zero operand", int'(mask_level), 1);
    mask_en = 1'b1; mask_en_lvl = 3'd3; mask_dis = 1'b1;
    tick();
    mask_en = 1'b0; mask_dis = 1'b0;
    check("R6 disable wins", int'(mask_level), 7);
  endtask

  task automatic t_traps();
    ill_req = 1'b1; swi_req = 1'b1; nmi_req = 1'b1;
    tick();
    ill_req = 1'b0; swi_req = 1'b0; nmi_req = 1'b0;
    tick();
    expect_req("R8 illegal first", 8'h02, 7);
    expect_req("R8 software second", 8'h03, 7);
    expect_req("R2 nmi under mask 7", 8'h04, 7);
    check("R9 drained", int'(irq_valid), 0);
  endtask

  task automatic t_priority();
    enable(1);
    cfg(3, 2); cfg(5, 5);
    src_req[3] = 1'b1; src_req[5] = 1'b1;
    tick();
    src_req[3] = 1'b0; src_req[5] = 1'b0;
    tick();
    expect_req("R3 highest level", 8'h15, 5);
    expect_req("R11 other kept", 8'h13, 2);
  endtask

  task automatic t_tie();
    cfg(4, 3); cfg(6, 3);
    src_req[4] = 1'b1; src_req[6] = 1'b1;
    tick();
    src_req[4] = 1'b0; src_req[6] = 1'b0;
    tick();
    expect_req("R10 lower index", 8'h14, 3);
    expect_req("R10 then higher index", 8'h16, 3);
  endtask

  task automatic t_stable();
    cfg(1, 1);
    pulse(1);
    tick();
    check("R12 presented", int'(irq_vector), 8'h11);
    pulse(5);
    tick(); tick();
    check("R12 held vector", int'(irq_vector), 8'h11);
    check("R12 held level", int'(irq_level), 1);
    ack();
    tick();
    expect_req("R12 next after ack", 8'h15, 5);
  endtask

  task automatic t_ack_edge();
    cfg(7, 6);
    pulse(7);
    tick();
    check("R11 first present", int'(irq_vector), 8'h17);
    src_req[7] = 1'b1; irq_ack = 1'b1;
    tick();
    src_req[7] = 1'b0; irq_ack = 1'b0;
    check("R12 gap", int'(irq_valid), 0);
    tick();
    expect_req("R11 edge during ack kept", 8'h17, 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; src_req = '0; nmi_req = 1'b0; swi_req = 1'b0; ill_req = 1'b0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_lvl = '0; mask_en = 1'b0; mask_en_lvl = '0;
    mask_dis = 1'b0; irq_ack = 1'b0;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (3) tick();
    t_reset();
    t_level_zero();
    t_mask_block();
    t_traps();
    t_priority();
    t_tie();
    t_stable();
    t_ack_edge();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule